// File: doc/BRIEF.md
# MDIO-Paged 32-bit Register Bridge

This block is a management-interface slave that reaches a 32-bit internal register space through ordinary 16-bit clause-22 MDIO frames. One fixed PHY address and register number act as a page register holding the upper word-address bits. Every data access folds the remaining word-address bits into the PHY address and register number it uses. The least significant bit of the register number picks the lower or upper 16-bit half of the word.

Software writes a word as upper half, then lower half, and reads a word as lower half, then upper half. The bridge holds an upper-half write in a shadow register and issues a single 32-bit internal write when the lower half arrives. A lower-half read fetches the whole word and keeps a snapshot, and the upper-half read that follows is served from that snapshot. Both halves therefore come from one internal access. MDC and MDIO are sampled on the system clock. The internal side is a simple strobe bus whose read data is valid in the cycle of the read strobe.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset both bus strobes and `mdio_oe` are low, and the page, shadow and snapshot registers are zero. A page read then returns 0, an upper-half read returns 0, and a lower-half write with no prior upper half writes 0 in data bits [31:16].
- R2: A write frame to PHY address 0x1f, register 0x10 loads the page from data bits [8:0]. A read frame to the same address returns the page zero-extended to 16 bits.
- R3: Data windows are PHY addresses 0x10 to 0x17. The word address driven on `bus_addr` is {page[8:0], PHY[2:0], REG[4:1]}, and the bus never raises both strobes in one cycle.
- R4: A write to an odd register (REG[0]=1) only stores the upper half in the shadow register. A write to an even register issues exactly one `bus_wr` pulse carrying {shadow, written data}.
- R5: A read of an even register issues exactly one `bus_rd` pulse, returns `bus_rdata[15:0]` and snapshots all 32 bits. A read of an odd register issues no bus read and returns snapshot bits [31:16], even if the read data has changed since.
- R6: The frame format is at least 32 preamble ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register number, a 2-bit turnaround and 16 data bits, all MSB first and sampled at the MDC rising edge. On a read the bridge leaves MDIO undriven during the first turnaround bit, drives 0 during the second, then drives the data, and releases MDIO after the last data bit.
- R7: A frame whose start field is 00, or whose opcode is 00 or 11, is ignored. Ignored means no bus strobe, `mdio_oe` stays low, and the page and shadow registers keep their values.
- R8: A frame addressed outside the windows (PHY 0x00 to 0x0f or 0x18 to 0x1e, or PHY 0x1f with any register other than 0x10) is ignored in the same sense as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the master |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| bus_addr | output | 16 | Internal word address |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | One-cycle internal write strobe |
| bus_rd | output | 1 | One-cycle internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid with `bus_rd` |

## Verification
Every one of the 128 word slots of one page is read as a lower-then-upper pair against read data that changes after each bus read. A wrong address fold or a live upper read therefore gives a wrong value, and the strobe count separates a fetched upper half from a snapshot. Upper-then-lower write pairs across three pages, including all-ones and zero, tell shadow-only writes apart from issued ones. Bad start, bad opcode and out-of-window frames are placed between a shadow write and its completing lower write, so any disturbance of page or shadow shows in the final data. The turnaround levels are sampled on a read to tell a correct handover from early or late driving.

// File: rtl/mdio_bridge_pkg.sv
// Shared widths, field codes and window decoders for the MDIO paged bridge.
// Assumes clause-22 frames with 5-bit PHY and register fields.
package mdio_bridge_pkg;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int PAGE_W    = 9;
    localparam int WIN_BITS  = 3;
    localparam int SLOT_BITS = REG_W - 1;
    localparam int ADDR_W    = PAGE_W + WIN_BITS + SLOT_BITS;
    localparam int HDR_BITS  = 2 + PHY_W + REG_W;

    localparam logic [PHY_W-1:0] PAGE_PHY = 5'h1f;
    localparam logic [REG_W-1:0] PAGE_REG = 5'h10;
    localparam logic [1:0]       OP_WR    = 2'b01;
    localparam logic [1:0]       OP_RD    = 2'b10;

    typedef struct packed {
        logic              wr;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regn;
        logic [HALF_W-1:0] data;
    } mdio_req_t;

    function automatic logic is_page(input logic [PHY_W-1:0] phy, input logic [REG_W-1:0] regn);
        return (phy == PAGE_PHY) && (regn == PAGE_REG);
    endfunction

    function automatic logic is_data(input logic [PHY_W-1:0] phy);
        return phy[PHY_W-1:WIN_BITS] == 2'b10;
    endfunction
endpackage

// File: rtl/mdc_sampler.sv
// Synchronises MDC and MDIO into the system clock and flags MDC rising edges.
// Assumes MDC is slower than a quarter of the system clock.
module mdc_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic bit_rise,
    output logic bit_val
);
    logic [STAGES-1:0] mdc_sr;
    logic [STAGES-1:0] dat_sr;
    logic              mdc_last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift one synchroniser stage for each line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mdc_sr[g] <= 1'b0;
                    dat_sr[g] <= 1'b1;
                end else if (g == 0) begin
                    mdc_sr[g] <= mdc;
                    dat_sr[g] <= mdio_i;
                end else begin
                    mdc_sr[g] <= mdc_sr[(g == 0) ? 0 : g-1];
                    dat_sr[g] <= dat_sr[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronised MDC level
    always_ff @(posedge clk) begin
        if (!rst_n) mdc_last <= 1'b0;
        else        mdc_last <= mdc_sr[STAGES-1];
    end

    assign bit_rise = mdc_sr[STAGES-1] & ~mdc_last;
    assign bit_val  = dat_sr[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
// Decodes clause-22 frames bit by bit, raises one request per accepted access
// and serialises read data back onto MDIO. Drops frames with bad start,
// opcode or address. Assumes read data is ready before the second turnaround bit.
module mdio_frame_engine
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic [HALF_W-1:0] rd_half,
    output logic              req_valid,
    output mdio_req_t         req,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int ONES_W  = $clog2(PRE_MIN + 1);
    localparam int CNT_MAX = (HDR_BITS > HALF_W) ? HDR_BITS : HALF_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    typedef enum logic [2:0] {S_IDLE, S_ST, S_HDR, S_TA, S_DATA} fstate_t;

    fstate_t             state;
    logic [ONES_W-1:0]   ones_cnt;
    logic [CNT_W-1:0]    cnt;
    logic [HDR_BITS-1:0] hdr_sr;
    logic [HALF_W-1:0]   dsh;
    logic [HALF_W-1:0]   osh;
    logic                is_rd;
    logic [PHY_W-1:0]    phy_q;
    logic [REG_W-1:0]    reg_q;

    logic [HDR_BITS-1:0] hdr_full;
    logic [1:0]          hdr_op;
    logic [PHY_W-1:0]    hdr_phy;
    logic [REG_W-1:0]    hdr_reg;
    logic                hdr_ok;

    // Header as it stands including the bit being sampled now
    always_comb begin
        hdr_full = {hdr_sr[HDR_BITS-2:0], bit_val};
        hdr_op   = hdr_full[HDR_BITS-1 -: 2];
        hdr_phy  = hdr_full[REG_W +: PHY_W];
        hdr_reg  = hdr_full[REG_W-1:0];
        hdr_ok   = ((hdr_op == OP_RD) || (hdr_op == OP_WR)) &&
                   (is_page(hdr_phy, hdr_reg) || is_data(hdr_phy));
    end

    // Frame state machine, request generation and MDIO drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ones_cnt  <= '0;
            cnt       <= '0;
            hdr_sr    <= '0;
            dsh       <= '0;
            osh       <= '0;
            is_rd     <= 1'b0;
            phy_q     <= '0;
            reg_q     <= '0;
            req_valid <= 1'b0;
            req       <= '0;
            mdio_o    <= 1'b0;
            mdio_oe   <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            if (bit_rise) begin
                case (state)
                    S_IDLE: begin
                        if (bit_val) begin
                            if (ones_cnt != ONES_W'(PRE_MIN)) ones_cnt <= ones_cnt + 1'b1;
                        end else begin
                            if (ones_cnt == ONES_W'(PRE_MIN)) state <= S_ST;
                            ones_cnt <= '0;
                        end
                    end
                    S_ST: begin
                        cnt   <= '0;
                        state <= bit_val ? S_HDR : S_IDLE;
                    end
                    S_HDR: begin
                        hdr_sr <= hdr_full;
                        if (cnt == CNT_W'(HDR_BITS - 1)) begin
                            cnt <= '0;
                            if (hdr_ok) begin
                                state <= S_TA;
                                is_rd <= (hdr_op == OP_RD);
                                phy_q <= hdr_phy;
                                reg_q <= hdr_reg;
                                if (hdr_op == OP_RD) begin
                                    req_valid <= 1'b1;
                                    req       <= '{wr: 1'b0, phy: hdr_phy, regn: hdr_reg, data: '0};
                                end
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_TA: begin
                        if (cnt == '0) begin
                            cnt <= 1;
                            if (is_rd) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                            end
                        end else begin
                            cnt   <= '0;
                            state <= S_DATA;
                            if (is_rd) begin
                                mdio_o <= rd_half[HALF_W-1];
                                osh    <= {rd_half[HALF_W-2:0], 1'b0};
                            end
                        end
                    end
                    S_DATA: begin
                        if (is_rd) begin
                            mdio_o <= osh[HALF_W-1];
                            osh    <= {osh[HALF_W-2:0], 1'b0};
                        end else begin
                            dsh <= {dsh[HALF_W-2:0], bit_val};
                        end
                        if (cnt == CNT_W'(HALF_W - 1)) begin
                            state    <= S_IDLE;
                            ones_cnt <= '0;
                            mdio_oe  <= 1'b0;
                            mdio_o   <= 1'b0;
                            if (!is_rd) begin
                                req_valid <= 1'b1;
                                req <= '{wr: 1'b1, phy: phy_q, regn: reg_q,
                                         data: {dsh[HALF_W-2:0], bit_val}};
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R4

    AST_OE_NO_WRITE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !(req_valid && req.wr)); // R6
endmodule

// File: rtl/page_word_mapper.sv
// Holds page, shadow and snapshot registers and turns frame requests into
// internal bus accesses. Assumes bus_rdata is valid in the bus_rd cycle.
module page_word_mapper
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  mdio_req_t         req,
    output logic [HALF_W-1:0] rd_half,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);
    logic [PAGE_W-1:0] page_q;
    logic [HALF_W-1:0] shadow_q;
    logic [WORD_W-1:0] snap_q;
    logic              snap_pend;
    logic [ADDR_W-1:0] word_addr;
    logic              req_page;
    logic              req_data;

    // Fold page, window bits and slot bits into one word address
    always_comb begin
        word_addr = {page_q, req.phy[WIN_BITS-1:0], req.regn[REG_W-1:1]};
        req_page  = is_page(req.phy, req.regn);
        req_data  = is_data(req.phy);
    end

    // Apply requests to page/shadow/snapshot and drive the bus strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= '0;
            shadow_q  <= '0;
            snap_q    <= '0;
            snap_pend <= 1'b0;
            rd_half   <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            if (snap_pend) begin
                snap_q    <= bus_rdata;
                rd_half   <= bus_rdata[HALF_W-1:0];
                snap_pend <= 1'b0;
            end
            if (req_valid) begin
                if (req_page) begin
                    if (req.wr) page_q  <= req.data[PAGE_W-1:0];
                    else        rd_half <= {{(HALF_W-PAGE_W){1'b0}}, page_q};
                end else if (req_data) begin
                    if (req.wr) begin
                        if (req.regn[0]) begin
                            shadow_q <= req.data;
                        end else begin
                            bus_wr    <= 1'b1;
                            bus_addr  <= word_addr;
                            bus_wdata <= {shadow_q, req.data};
                        end
                    end else begin
                        if (req.regn[0]) begin
                            rd_half <= snap_q[WORD_W-1:HALF_W];
                        end else begin
                            bus_rd    <= 1'b1;
                            bus_addr  <= word_addr;
                            snap_pend <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    AST_WR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(req_valid && req.wr && !req.regn[0])); // R4

    AST_RD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> $past(req_valid && !req.wr && !req.regn[0])); // R5

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_pend |=> $stable(snap_q)); // R5

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req.wr && req_page) |=> $stable(page_q)); // R2
endmodule

// File: rtl/mdio_page_bridge.sv
// Top of the MDIO paged 32-bit register bridge: sampler, frame engine and
// word mapper in a chain. Assumes MDIO is an open-drain line with pull-up.
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_MIN     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);
    logic              bit_rise;
    logic              bit_val;
    logic              req_valid;
    mdio_req_t         req;
    logic [HALF_W-1:0] rd_half;

    mdc_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
        .bit_rise(bit_rise), .bit_val(bit_val)
    );

    mdio_frame_engine #(.PRE_MIN(PRE_MIN)) u_engine (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_val(bit_val),
        .rd_half(rd_half), .req_valid(req_valid), .req(req),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    page_word_mapper u_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req),
        .rd_half(rd_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R3

    AST_OE_NOT_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !bus_wr); // R6
endmodule

// File: tb/mdio_page_bridge_tb.sv
// Self-checking bench: MDIO master model, bus monitor and a read-data model
// that changes after every bus read.
module mdio_page_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MDC_HALF   = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        mdc = 0;
    logic        mdio_i = 1;
    logic        mdio_o, mdio_oe;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
    logic [15:0] last_wa, last_ra, gen = 0;
    logic [31:0] last_wd;
    logic        rd_prev = 0;
    logic        smp_o, smp_oe, ta1_oe, ta2_oe, ta2_o, tail_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] g);
        return {a ^ g ^ 16'h5a00, ~a ^ {g[7:0], g[15:8]}};
    endfunction

    assign bus_rdata = model(bus_addr, gen);

    mdio_page_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata)
    );

    // Bus and MDIO monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr) begin wr_cnt++; last_wa = bus_addr; last_wd = bus_wdata; end
            if (bus_rd) begin rd_cnt++; last_ra = bus_addr; end
            if (mdio_oe) oe_cnt++;
            if (rd_prev && !bus_rd) gen = gen + 16'h0137;
            rd_prev = bus_rd;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        mdio_i = b;
        repeat (MDC_HALF) @(negedge clk);
        smp_o = mdio_o;
        smp_oe = mdio_oe;
        mdc = 1;
        repeat (MDC_HALF) @(negedge clk);
        mdc = 0;
    endtask

    task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd, input bit rd_shape,
                         output logic [15:0] rd);
        rd = '0;
        for (int i = 0; i < 32; i++) tick(1'b1);
        tick(st[1]); tick(st[0]); tick(op[1]); tick(op[0]);
        for (int i = 4; i >= 0; i--) tick(phy[i]);
        for (int i = 4; i >= 0; i--) tick(rg[i]);
        if (rd_shape) begin
            tick(1'b1); ta1_oe = smp_oe;
            tick(1'b1); ta2_oe = smp_oe; ta2_o = smp_o;
            for (int i = 15; i >= 0; i--) begin tick(1'b1); rd[i] = smp_o; end
            tick(1'b1); tail_oe = smp_oe;
        end else begin
            tick(1'b1); tick(1'b0);
            for (int i = 15; i >= 0; i--) tick(wd[i]);
            tick(1'b1);
        end
    endtask

    task automatic mwrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        logic [15:0] dummy;
        frame(2'b01, 2'b01, phy, rg, wd, 1'b0, dummy);
    endtask

    task automatic mread(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] rd);
        frame(2'b01, 2'b10, phy, rg, 16'h0, 1'b1, rd);
    endtask

    initial begin
        logic [15:0] rv;
        logic [15:0] ea, g0;
        logic [8:0]  pg;
        int w0, r0, o0;
        logic [8:0] pages [3];
        pages[0] = 9'h000; pages[1] = 9'h1ff; pages[2] = 9'h0c3;

        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset oe", {31'b0, mdio_oe}, 0);
        chk("R1 reset wr", {31'b0, bus_wr}, 0);
        chk("R1 reset rd", {31'b0, bus_rd}, 0);

        mread(5'h1f, 5'h10, rv);
        chk("R1 page zero", {16'b0, rv}, 0);
        chk("R6 ta1 undriven", {31'b0, ta1_oe}, 0);
        chk("R6 ta2 driven", {31'b0, ta2_oe}, 1);
        chk("R6 ta2 level", {31'b0, ta2_o}, 0);
        chk("R6 released", {31'b0, tail_oe}, 0);
        mread(5'h10, 5'h01, rv);
        chk("R1 snapshot zero", {16'b0, rv}, 0);
        chk("R5 no rd on upper", rd_cnt, 0);
        mwrite(5'h10, 5'h00, 16'h1234);
        chk("R1 shadow zero wr count", wr_cnt, 1);
        chk("R1 shadow zero data", last_wd, 32'h0000_1234);
        chk("R3 addr zero", {16'b0, last_wa}, 0);

        mwrite(5'h1f, 5'h10, 16'hfeab);
        mread(5'h1f, 5'h10, rv);
        chk("R2 page readback", {16'b0, rv}, 32'h0000_00ab);

        // Read sweep over all slots of one page
        pg = 9'h15a;
        mwrite(5'h1f, 5'h10, {7'b0, pg});
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 16; s++) begin
                ea = {pg, p[2:0], s[3:0]};
                r0 = rd_cnt;
                g0 = gen;
                mread({2'b10, p[2:0]}, {s[3:0], 1'b0}, rv);
                chk("R5 lower rd count", rd_cnt - r0, 1);
                chk("R3 rd addr", {16'b0, last_ra}, {16'b0, ea});
                chk("R5 lower data", {16'b0, rv}, {16'b0, model(ea, g0)[15:0]});
                r0 = rd_cnt;
                mread({2'b10, p[2:0]}, {s[3:0], 1'b1}, rv);
                chk("R5 upper no rd", rd_cnt - r0, 0);
                chk("R5 upper snapshot", {16'b0, rv}, {16'b0, model(ea, g0)[31:16]});
            end
        end

        // Write pairs across several pages
        for (int k = 0; k < 3; k++) begin
            mwrite(5'h1f, 5'h10, {7'b0, pages[k]});
            for (int p = 0; p < 8; p++) begin
                logic [3:0]  s;
                logic [15:0] hv, lv;
                s  = 4'(p * 5 + k * 3);
                hv = 16'(16'hc000 + p * 16'h0101 + k);
                lv = (k == 1) ? 16'hffff : 16'(p * 16'h1111);
                w0 = wr_cnt;
                mwrite({2'b10, p[2:0]}, {s, 1'b1}, hv);
                chk("R4 upper no wr", wr_cnt - w0, 0);
                mwrite({2'b10, p[2:0]}, {s, 1'b0}, lv);
                chk("R4 lower one wr", wr_cnt - w0, 1);
                chk("R3 wr addr", {16'b0, last_wa}, {16'b0, pages[k], p[2:0], s});
                chk("R4 wr data", last_wd, {hv, lv});
            end
        end

        // Ignored frames between a shadow write and its completion
        mwrite(5'h1f, 5'h10, 16'h0021);
        mwrite(5'h12, 5'h03, 16'haaaa);
        w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
        frame(2'b00, 2'b01, 5'h1f, 5'h10, 16'h0055, 1'b0, rv);
        frame(2'b00, 2'b01, 5'h12, 5'h03, 16'h5555, 1'b0, rv);
        frame(2'b01, 2'b11, 5'h1f, 5'h10, 16'h0066, 1'b0, rv);
        frame(2'b01, 2'b00, 5'h12, 5'h03, 16'h6666, 1'b0, rv);
        frame(2'b01, 2'b11, 5'h12, 5'h02, 16'h0000, 1'b1, rv);
        frame(2'b01, 2'b00, 5'h12, 5'h02, 16'h0000, 1'b1, rv);
        chk("R7 no oe", oe_cnt - o0, 0);
        chk("R7 no wr", wr_cnt - w0, 0);
        chk("R7 no rd", rd_cnt - r0, 0);

        o0 = oe_cnt;
        mwrite(5'h08, 5'h03, 16'h7777);
        mwrite(5'h18, 5'h03, 16'h7777);
        mwrite(5'h1f, 5'h11, 16'h0033);
        mwrite(5'h1e, 5'h10, 16'h0044);
        mread(5'h0f, 5'h02, rv);
        mread(5'h1f, 5'h00, rv);
        chk("R8 no oe", oe_cnt - o0, 0);
        chk("R8 no wr", wr_cnt - w0, 0);
        chk("R8 no rd", rd_cnt - r0, 0);
        mread(5'h1f, 5'h10, rv);
        chk("R7 R8 page kept", {16'b0, rv}, 32'h0000_0021);
        mwrite(5'h12, 5'h02, 16'h0bcd);
        chk("R7 R8 single wr", wr_cnt - w0, 1);
        chk("R7 R8 shadow kept", last_wd, 32'haaaa_0bcd);
        chk("R3 final addr", {16'b0, last_wa}, {16'b0, 9'h021, 3'd2, 4'd1});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule